// File: doc/BRIEF.md
# DMA Channel Interrupt Collector

This block gathers the per-channel event pulses of a multi-channel DMA engine into a single level interrupt. Each channel reports four kinds of event: completion of a whole descriptor chain, completion of a single descriptor node, and two separate error conditions. For every kind of event the block keeps a latched raw flag per channel, an enable mask per channel, and a read-only masked view. A summary word sets bit i whenever any enabled event of channel i is pending, and the interrupt output is the OR of that summary.

Software reaches the block through a word-addressed register port. It clears a flag by writing a one to its bit in the raw register of that event kind. A per-channel halt pulse, raised when a channel is torn down, clears all four raw flags of that channel so that a stale completion is never reported. A priority register is also kept as plain storage; writing zero puts every channel on the same level.

Top module: `dma_irq_collector`

Register addresses (word index): 0 summary (read-only); 1..4 masked status for chain, node, error A, error B (read-only); 5..8 masks in the same kind order (read/write, 1 = enabled); 9..12 raw flags in the same kind order (write one to clear); 13 priority (read/write); 14 and 15 unused.

## Requirements
- R1: After reset every raw flag, mask and the priority register are zero, irq is low, and every address reads zero.
- R2: An event pulse on channel i sets that channel's raw flag of that kind on the clock edge where it is sampled, whether or not the mask bit is set.
- R3: Writing the raw register of a kind clears each flag whose wdata bit is 1 and leaves each flag whose wdata bit is 0 unchanged.
- R4: When an event pulse and a clear (register write of 1 or channel halt) hit the same flag in the same cycle, the flag ends up set.
- R5: The mask registers read back what was written; the masked status of a kind reads raw AND mask, and writes to a masked status address change nothing.
- R6: Summary bit i is 1 exactly when at least one of the four masked status bits of channel i is 1.
- R7: irq is a registered level that is high one cycle after any summary bit is 1 and stays high until all enabled pending flags are cleared or masked.
- R8: A halt pulse on channel i clears all four raw flags of channel i and no flag of any other channel.
- R9: The priority register reads back the written value; writing zero reads back zero.
- R10: Addresses 14 and 15 read zero and writes to them change no register.
- R11: rdata is registered: it shows the register selected by addr at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data for addr |
| ev_chain | input | 16 | Chain-complete event pulses, one per channel |
| ev_node | input | 16 | Node-complete event pulses, one per channel |
| ev_err_a | input | 16 | First error event pulses, one per channel |
| ev_err_b | input | 16 | Second error event pulses, one per channel |
| ch_halt | input | 16 | Channel teardown pulses clearing all flags of a channel |
| irq | output | 1 | Combined level interrupt |

## Verification
The hardest situation to reach from the ports is a collision: an event pulse landing in the very cycle that software clears the same flag, or that the channel is halted. The bench drives the event input and the write strobe (or halt) in the same low clock phase so both are sampled on one edge, then reads the raw register back to see the set win. A second hard case is proving that a halt leaves neighbouring channels alone, which the bench covers by loading flags on several channels and kinds before halting one.

// File: rtl/dirq_pkg.sv
package dirq_pkg;
  localparam int NUM_KINDS = 4;

  typedef enum logic [1:0] {
    KIND_CHAIN = 2'd0,
    KIND_NODE  = 2'd1,
    KIND_ERR_A = 2'd2,
    KIND_ERR_B = 2'd3
  } ev_kind_e;

  localparam logic [3:0] A_SUMMARY  = 4'd0;
  localparam logic [3:0] A_PEND_LO  = 4'd1;
  localparam logic [3:0] A_MASK_LO  = 4'd5;
  localparam logic [3:0] A_RAW_LO   = 4'd9;
  localparam logic [3:0] A_PRIO     = 4'd13;
endpackage

// File: rtl/dirq_kind_bank.sv
module dirq_kind_bank #(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] ev,
  input  logic [NUM_CH-1:0] halt,
  input  logic              mask_we,
  input  logic              raw_we,
  input  logic [NUM_CH-1:0] wbits,
  output logic [NUM_CH-1:0] raw,
  output logic [NUM_CH-1:0] mask,
  output logic [NUM_CH-1:0] pend
);
  logic [NUM_CH-1:0] clr;

  always_comb begin
    clr = halt;
    if (raw_we) clr = clr | wbits;
  end

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_flag
      always_ff @(posedge clk) begin
        if (rst)        raw[g] <= 1'b0;
        else if (ev[g]) raw[g] <= 1'b1;
        else if (clr[g]) raw[g] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)          mask <= '0;
    else if (mask_we) mask <= wbits;
  end

  assign pend = raw & mask;

  assert_latch_R2: assert property (@(posedge clk) disable iff (rst)
    (|ev) |=> ((raw & $past(ev)) == $past(ev)));

  assert_w1c_R3: assert property (@(posedge clk) disable iff (rst)
    raw_we |=> ((raw & $past(wbits & ~ev)) == '0));

  assert_halt_R8: assert property (@(posedge clk) disable iff (rst)
    (|halt) |=> ((raw & $past(halt & ~ev)) == '0));

  assert_keep_R3: assert property (@(posedge clk) disable iff (rst)
    ((raw_we == 1'b0) && (halt == '0) && (ev == '0)) |=> $stable(raw));

  assert_mask_R5: assert property (@(posedge clk) disable iff (rst)
    mask_we |=> (mask == $past(wbits)));
endmodule

// File: rtl/dirq_read_mux.sv
module dirq_read_mux #(
  parameter int NUM_CH = 16,
  parameter int DATA_W = 32,
  parameter int PRIO_W = 32
) (
  input  logic [3:0]                       sel,
  input  logic [NUM_CH-1:0]                summary,
  input  logic [dirq_pkg::NUM_KINDS*NUM_CH-1:0] pend_all,
  input  logic [dirq_pkg::NUM_KINDS*NUM_CH-1:0] mask_all,
  input  logic [dirq_pkg::NUM_KINDS*NUM_CH-1:0] raw_all,
  input  logic [PRIO_W-1:0]                prio,
  output logic [DATA_W-1:0]                word
);
  import dirq_pkg::*;

  always_comb begin
    word = '0;
    if (sel == A_SUMMARY) begin
      word[NUM_CH-1:0] = summary;
    end else if (sel == A_PRIO) begin
      word[PRIO_W-1:0] = prio;
    end else begin
      for (int k = 0; k < NUM_KINDS; k++) begin
        if (sel == A_PEND_LO + 4'(k)) word[NUM_CH-1:0] = pend_all[k*NUM_CH +: NUM_CH];
        if (sel == A_MASK_LO + 4'(k)) word[NUM_CH-1:0] = mask_all[k*NUM_CH +: NUM_CH];
        if (sel == A_RAW_LO  + 4'(k)) word[NUM_CH-1:0] = raw_all[k*NUM_CH +: NUM_CH];
      end
    end
  end
endmodule

// File: rtl/dma_irq_collector.sv
module dma_irq_collector #(
  parameter int NUM_CH = 16,
  parameter int DATA_W = 32,
  parameter int PRIO_W = 2 * NUM_CH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [3:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [NUM_CH-1:0] ev_chain,
  input  logic [NUM_CH-1:0] ev_node,
  input  logic [NUM_CH-1:0] ev_err_a,
  input  logic [NUM_CH-1:0] ev_err_b,
  input  logic [NUM_CH-1:0] ch_halt,
  output logic              irq
);
  import dirq_pkg::*;

  localparam int ALL_W = NUM_KINDS * NUM_CH;

  logic [ALL_W-1:0]  ev_all, raw_all, mask_all, pend_all;
  logic [NUM_CH-1:0] summary;
  logic [PRIO_W-1:0] prio;
  logic [DATA_W-1:0] rd_word;

  assign ev_all = {ev_err_b, ev_err_a, ev_node, ev_chain};

  genvar k;
  generate
    for (k = 0; k < NUM_KINDS; k++) begin : g_kind
      dirq_kind_bank #(.NUM_CH(NUM_CH)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev_all[k*NUM_CH +: NUM_CH]),
        .halt    (ch_halt),
        .mask_we (wr_en && (addr == A_MASK_LO + 4'(k))),
        .raw_we  (wr_en && (addr == A_RAW_LO + 4'(k))),
        .wbits   (wdata[NUM_CH-1:0]),
        .raw     (raw_all[k*NUM_CH +: NUM_CH]),
        .mask    (mask_all[k*NUM_CH +: NUM_CH]),
        .pend    (pend_all[k*NUM_CH +: NUM_CH])
      );
    end
  endgenerate

  always_comb begin
    summary = '0;
    for (int j = 0; j < NUM_KINDS; j++) summary = summary | pend_all[j*NUM_CH +: NUM_CH];
  end

  always_ff @(posedge clk) begin
    if (rst)                          prio <= '0;
    else if (wr_en && addr == A_PRIO) prio <= wdata[PRIO_W-1:0];
  end

  dirq_read_mux #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .PRIO_W(PRIO_W)) u_rmux (
    .sel      (addr),
    .summary  (summary),
    .pend_all (pend_all),
    .mask_all (mask_all),
    .raw_all  (raw_all),
    .prio     (prio),
    .word     (rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      rdata <= rd_word;
      irq   <= |summary;
    end
  end

  assert_irq_level_R7: assert property (@(posedge clk) disable iff (rst)
    (|(raw_all & mask_all)) |=> irq);

  assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    ((raw_all & mask_all) == '0) |=> !irq);

  assert_prio_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_PRIO) |=> (prio == $past(wdata[PRIO_W-1:0])));

  assert_unmapped_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr > A_PRIO) |=> ($stable(mask_all) && $stable(prio)));
endmodule

// File: tb/dma_irq_collector_tb.sv
module dma_irq_collector_tb;
  localparam int N = 16;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic [N-1:0] ev_chain = '0, ev_node = '0, ev_err_a = '0, ev_err_b = '0, ch_halt = '0;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dma_irq_collector #(.NUM_CH(N), .DATA_W(W)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .ev_chain(ev_chain), .ev_node(ev_node), .ev_err_a(ev_err_a), .ev_err_b(ev_err_b),
    .ch_halt(ch_halt), .irq(irq)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [W-1:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [W-1:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic pulse(input int kind, input logic [N-1:0] v);
    @(negedge clk);
    case (kind)
      0: ev_chain = v; 1: ev_node = v; 2: ev_err_a = v; default: ev_err_b = v;
    endcase
    @(negedge clk);
    ev_chain = '0; ev_node = '0; ev_err_a = '0; ev_err_b = '0;
  endtask

  task automatic t_reset();
    logic [W-1:0] d;
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), d);
      check("R1 reset read", d, '0);
    end
    check("R1 irq low", {31'd0, irq}, '0);
  endtask

  task automatic t_latch_unmasked();
    logic [W-1:0] d;
    pulse(0, 16'h0008);
    rd(4'd9, d);  check("R2 raw chain latched while masked", d, 32'h8);
    rd(4'd1, d);  check("R5 masked chain blocked", d, 32'h0);
    rd(4'd0, d);  check("R6 summary empty", d, 32'h0);
    check("R7 irq low while masked", {31'd0, irq}, '0);
  endtask

  task automatic t_mask_enable();
    logic [W-1:0] d;
    wr(4'd5, 32'h0000ffff);
    rd(4'd5, d);  check("R5 mask readback", d, 32'hffff);
    rd(4'd1, d);  check("R5 masked chain", d, 32'h8);
    rd(4'd0, d);  check("R6 summary ch3", d, 32'h8);
    check("R7 irq high", {31'd0, irq}, 32'h1);
  endtask

  task automatic t_w1c();
    logic [W-1:0] d;
    wr(4'd9, 32'h0);
    rd(4'd9, d);  check("R3 write zero keeps flag", d, 32'h8);
    check("R7 irq holds", {31'd0, irq}, 32'h1);
    wr(4'd9, 32'h8);
    rd(4'd9, d);  check("R3 write one clears", d, 32'h0);
    check("R7 irq drops", {31'd0, irq}, '0);
  endtask

  task automatic t_collide();
    logic [W-1:0] d;
    pulse(1, 16'h0020);
    @(negedge clk); wr_en = 1'b1; addr = 4'd10; wdata = 32'h20; ev_node = 16'h0020;
    @(negedge clk); wr_en = 1'b0; ev_node = '0;
    rd(4'd10, d); check("R4 event beats clear write", d, 32'h20);
    wr(4'd10, 32'h20);
    rd(4'd10, d); check("R3 clear after collision", d, 32'h0);
  endtask

  task automatic t_ro();
    logic [W-1:0] d;
    pulse(0, 16'h0001);
    wr(4'd1, 32'h0000ffff);
    rd(4'd1, d);  check("R5 masked status read-only", d, 32'h1);
    wr(4'd9, 32'h1);
  endtask

  task automatic t_multi();
    logic [W-1:0] d;
    wr(4'd8, 32'h00008001);
    wr(4'd7, 32'h00000002);
    wr(4'd6, 32'h00000000);
    pulse(3, 16'h8003);
    pulse(2, 16'h0002);
    pulse(1, 16'h0004);
    rd(4'd4, d);  check("R5 err_b masked", d, 32'h8001);
    rd(4'd0, d);  check("R6 summary multi", d, 32'h8003);
    rd(4'd10, d); check("R2 node raw while mask off", d, 32'h4);
  endtask

  task automatic t_halt();
    logic [W-1:0] d;
    wr(4'd9, 32'hffff); wr(4'd10, 32'hffff); wr(4'd11, 32'hffff); wr(4'd12, 32'hffff);
    pulse(0, 16'h0084); pulse(1, 16'h0004); pulse(2, 16'h0004); pulse(3, 16'h0004);
    @(negedge clk); ch_halt = 16'h0084; ev_chain = 16'h0080;
    @(negedge clk); ch_halt = '0; ev_chain = '0;
    rd(4'd9, d);  check("R8 halt chain keeps ch7 (R4 event wins)", d, 32'h80);
    rd(4'd10, d); check("R8 halt node", d, 32'h0);
    rd(4'd11, d); check("R8 halt err_a", d, 32'h0);
    rd(4'd12, d); check("R8 halt err_b", d, 32'h0);
    pulse(1, 16'h0100);
    @(negedge clk); ch_halt = 16'h0002;
    @(negedge clk); ch_halt = '0;
    rd(4'd10, d); check("R8 halt spares other channels", d, 32'h100);
  endtask

  task automatic t_prio_latency();
    logic [W-1:0] d;
    wr(4'd13, 32'hA5A50003);
    rd(4'd13, d); check("R9 prio readback", d, 32'hA5A50003);
    @(negedge clk); addr = 4'd5;
    #5 check("R11 rdata still old before edge", rdata, 32'hA5A50003);
    @(negedge clk); check("R11 rdata new after edge", rdata, 32'hffff);
    wr(4'd13, 32'h0);
    rd(4'd13, d); check("R9 prio zero", d, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [W-1:0] d;
    wr(4'd14, 32'hffffffff);
    wr(4'd15, 32'hffffffff);
    rd(4'd14, d); check("R10 addr14 reads zero", d, 32'h0);
    rd(4'd15, d); check("R10 addr15 reads zero", d, 32'h0);
    rd(4'd13, d); check("R10 prio untouched", d, 32'h0);
    rd(4'd5, d);  check("R10 mask untouched", d, 32'hffff);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_latch_unmasked();
    t_mask_enable();
    t_w1c();
    t_collide();
    t_ro();
    t_multi();
    t_halt();
    t_prio_latency();
    t_unmapped();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule